// File: doc/BRIEF.md
# Timer Compare Output Unit

The unit holds a compare value and checks it for equality, every clock cycle, against one of two free-running timer counts. A select input picks the timer. When the chosen count first becomes equal to the compare value, a mode field picks the action. The unit can drive an output latch high or low, toggle it, or raise only the interrupt flag. In its trigger mode it sends a one-cycle reset pulse to the selected timer and, if the converter is enabled, a one-cycle start request to an A/D converter. This path never touches the timer's own overflow flag. Software programs the unit through a small register write port. The timers and the converter are outside the unit.

The unit is built around a three-state match tracker:
- ST_OFF: the mode field holds a code with no action.
- ST_ARMED: the unit is enabled and the selected count differs from the compare value.
- ST_HELD: the selected count stayed equal after a match was taken.

Transitions:
- Any state goes to ST_OFF when the mode has no action.
- ST_OFF or ST_ARMED goes to ST_HELD on equality. This transition is the match event.
- ST_HELD goes back to ST_ARMED once the count differs.
- ST_OFF goes to ST_ARMED when the unit is enabled and there is no equality.

Top module: `tcmp_unit`

## Requirements
- R1: A write with `cfg_addr`=0 loads `cfg_wdata` as the compare value. A match event happens when the count picked by `src_sel` (0 = timer A, 1 = timer B) equals that value. The count of the timer that is not selected has no effect.
- R2: Only the first cycle of equality is a match event. A count held equal for several cycles produces one action and one flag set. After the count differs, a new equality produces a new event.
- R3: With mode field 4'b1000, a match event drives `pin_out` high one cycle after the matching cycle.
- R4: With mode field 4'b1001, a match event drives `pin_out` low one cycle after the matching cycle.
- R5: With mode field 4'b0010, a match event inverts `pin_out` one cycle after the matching cycle.
- R6: With mode field 4'b1010, a match event leaves `pin_out` unchanged and only sets the interrupt flag.
- R7: With mode field 4'b1011, a match event gives a one-cycle pulse on `tmr_a_rst` (when `src_sel`=0) or on `tmr_b_rst` (when `src_sel`=1), never on both. The pulse appears one cycle after the matching cycle.
- R8: In mode 4'b1011, `adc_start` pulses for one cycle together with the timer reset, but only if `adc_en` was high in the matching cycle.
- R9: Every match event, in any enabled mode, sets `irq_flag`. The flag stays set until `irq_clr` is high or a control write (`cfg_addr`=1) has bit 7 set. A set in the same cycle as a clear wins.
- R10: A control write of all zeros forces `pin_out` low, and this wins over a same-cycle set. Mode 4'b0000 and every code not listed in R3 to R7 take no action on a match.
- R11: The control write stores the mode in bits 3:0 and the output enable in bit 4. `pin_oe` reflects the stored enable bit.
- R12: After reset, `pin_out`, `pin_oe`, `irq_flag`, `tmr_a_rst`, `tmr_b_rst` and `adc_start` are all low, and the unit is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 = compare value, 1 = control |
| cfg_wdata | input | 16 | Write data |
| cnt_a | input | 16 | Timer A count |
| cnt_b | input | 16 | Timer B count |
| src_sel | input | 1 | Timer select, 1 = timer B |
| adc_en | input | 1 | A/D converter enabled |
| irq_clr | input | 1 | Interrupt flag clear |
| pin_out | output | 1 | Compare output latch level |
| pin_oe | output | 1 | Output enable for the pin |
| irq_flag | output | 1 | Compare interrupt flag |
| tmr_a_rst | output | 1 | Reset pulse to timer A |
| tmr_b_rst | output | 1 | Reset pulse to timer B |
| adc_start | output | 1 | A/D conversion start pulse |

## Verification
Two functions can fall in the same cycle, and both are checked:
- A match event that sets the interrupt flag, together with a flag clear from `irq_clr` or from a control write with bit 7 set.
- A match that drives the latch high, together with a control write of all zeros.

The bench provokes both collisions with directed cycles in which the count becomes equal at the same time as the clear or the write. It also brings them about by chance in a long random run over a small count range. A reference model, built from the requirements, applies the rule that the set wins for the flag and the zero write wins for the latch. It compares every output one cycle after each stimulus.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

    localparam logic [3:0] MODE_OFF     = 4'b0000;
    localparam logic [3:0] MODE_TOGGLE  = 4'b0010;
    localparam logic [3:0] MODE_SET     = 4'b1000;
    localparam logic [3:0] MODE_CLR     = 4'b1001;
    localparam logic [3:0] MODE_SWI     = 4'b1010;
    localparam logic [3:0] MODE_SPECIAL = 4'b1011;

    localparam int CTRL_OE_BIT  = 4;
    localparam int CTRL_CLR_BIT = 7;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_HELD  = 2'd2
    } cmp_state_e;

    typedef enum logic [2:0] {
        ACT_NONE   = 3'd0,
        ACT_SET    = 3'd1,
        ACT_CLR    = 3'd2,
        ACT_TOGGLE = 3'd3,
        ACT_FLAG   = 3'd4,
        ACT_TRIG   = 3'd5
    } cmp_act_e;

    function automatic cmp_act_e decode_mode(input logic [3:0] m);
        cmp_act_e a;
        unique case (m)
            MODE_SET:     a = ACT_SET;
            MODE_CLR:     a = ACT_CLR;
            MODE_TOGGLE:  a = ACT_TOGGLE;
            MODE_SWI:     a = ACT_FLAG;
            MODE_SPECIAL: a = ACT_TRIG;
            default:      a = ACT_NONE;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/tcmp_regs.sv
module tcmp_regs
    import tcmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_addr,
    input  logic [CNT_W-1:0] cfg_wdata,
    output logic [CNT_W-1:0] cmp_val,
    output logic [3:0]       mode,
    output logic             oe,
    output logic             ctrl_zero_wr,
    output logic             flag_clr_wr
);
    logic ctrl_wr;

    always_comb begin
        ctrl_wr      = cfg_we && cfg_addr;
        ctrl_zero_wr = ctrl_wr && (cfg_wdata == '0);
        flag_clr_wr  = ctrl_wr && cfg_wdata[CTRL_CLR_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_val <= '0;
            mode    <= MODE_OFF;
            oe      <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_addr) begin
                mode <= cfg_wdata[3:0];
                oe   <= cfg_wdata[CTRL_OE_BIT];
            end else begin
                cmp_val <= cfg_wdata;
            end
        end
    end

    AST_OE_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (oe == $past(cfg_wdata[CTRL_OE_BIT])))
        else $error("oe mismatch"); // R11

endmodule

// File: rtl/tcmp_match.sv
module tcmp_match
    import tcmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_a,
    input  logic [CNT_W-1:0] cnt_b,
    input  logic             src_sel,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [3:0]       mode,
    output logic             match_evt,
    output cmp_act_e         evt_act
);
    cmp_state_e       state_q, state_d;
    logic [CNT_W-1:0] sel_cnt;
    logic             equal;
    logic             enabled;
    cmp_act_e         act;

    always_comb begin
        sel_cnt = src_sel ? cnt_b : cnt_a;
        equal   = (sel_cnt == cmp_val);
        act     = decode_mode(mode);
        enabled = (act != ACT_NONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (enabled) state_d = equal ? ST_HELD : ST_ARMED;
            end
            ST_ARMED: begin
                if (!enabled)   state_d = ST_OFF;
                else if (equal) state_d = ST_HELD;
            end
            ST_HELD: begin
                if (!enabled)   state_d = ST_OFF;
                else if (!equal) state_d = ST_ARMED;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        match_evt = 1'b0;
        evt_act   = ACT_NONE;
        unique case (state_q)
            ST_OFF, ST_ARMED: begin
                if (enabled && equal) begin
                    match_evt = 1'b1;
                    evt_act   = act;
                end
            end
            default: ;
        endcase
    end

    AST_SINGLE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> !match_evt)
        else $error("repeated match event"); // R2

    AST_EVENT_NEEDS_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |-> ((src_sel ? cnt_b : cnt_a) == cmp_val))
        else $error("event without equality"); // R1

endmodule

// File: rtl/tcmp_action.sv
module tcmp_action
    import tcmp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     match_evt,
    input  cmp_act_e evt_act,
    input  logic     src_sel,
    input  logic     adc_en,
    input  logic     irq_clr,
    input  logic     flag_clr_wr,
    input  logic     ctrl_zero_wr,
    output logic     latch_q,
    output logic     flag_q,
    output logic     rst_a_q,
    output logic     rst_b_q,
    output logic     adc_q
);
    logic latch_d, flag_d, trig;

    always_comb begin
        latch_d = latch_q;
        if (match_evt) begin
            unique case (evt_act)
                ACT_SET:    latch_d = 1'b1;
                ACT_CLR:    latch_d = 1'b0;
                ACT_TOGGLE: latch_d = ~latch_q;
                default:    latch_d = latch_q;
            endcase
        end
        if (ctrl_zero_wr) latch_d = 1'b0;

        if (match_evt)                     flag_d = 1'b1;
        else if (irq_clr || flag_clr_wr)   flag_d = 1'b0;
        else                               flag_d = flag_q;

        trig = match_evt && (evt_act == ACT_TRIG);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= 1'b0;
            flag_q  <= 1'b0;
            rst_a_q <= 1'b0;
            rst_b_q <= 1'b0;
            adc_q   <= 1'b0;
        end else begin
            latch_q <= latch_d;
            flag_q  <= flag_d;
            rst_a_q <= trig && !src_sel;
            rst_b_q <= trig && src_sel;
            adc_q   <= trig && adc_en;
        end
    end

    AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> flag_q)
        else $error("flag not set"); // R9

    AST_ADC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        adc_q |-> $past(adc_en))
        else $error("adc start without enable"); // R8

    AST_ONE_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_a_q && rst_b_q))
        else $error("both timers reset"); // R7

    AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_a_q || rst_b_q) |=> !(rst_a_q || rst_b_q))
        else $error("reset pulse too long"); // R7

    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_zero_wr |=> !latch_q)
        else $error("zero write left latch high"); // R10

endmodule

// File: rtl/tcmp_unit.sv
module tcmp_unit
    import tcmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_addr,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic [CNT_W-1:0] cnt_a,
    input  logic [CNT_W-1:0] cnt_b,
    input  logic             src_sel,
    input  logic             adc_en,
    input  logic             irq_clr,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             irq_flag,
    output logic             tmr_a_rst,
    output logic             tmr_b_rst,
    output logic             adc_start
);
    logic [CNT_W-1:0] cmp_val;
    logic [3:0]       mode;
    logic             oe;
    logic             ctrl_zero_wr;
    logic             flag_clr_wr;
    logic             match_evt;
    cmp_act_e         evt_act;

    tcmp_regs #(.CNT_W(CNT_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .cmp_val      (cmp_val),
        .mode         (mode),
        .oe           (oe),
        .ctrl_zero_wr (ctrl_zero_wr),
        .flag_clr_wr  (flag_clr_wr)
    );

    tcmp_match #(.CNT_W(CNT_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_a     (cnt_a),
        .cnt_b     (cnt_b),
        .src_sel   (src_sel),
        .cmp_val   (cmp_val),
        .mode      (mode),
        .match_evt (match_evt),
        .evt_act   (evt_act)
    );

    tcmp_action u_action (
        .clk          (clk),
        .rst_n        (rst_n),
        .match_evt    (match_evt),
        .evt_act      (evt_act),
        .src_sel      (src_sel),
        .adc_en       (adc_en),
        .irq_clr      (irq_clr),
        .flag_clr_wr  (flag_clr_wr),
        .ctrl_zero_wr (ctrl_zero_wr),
        .latch_q      (pin_out),
        .flag_q       (irq_flag),
        .rst_a_q      (tmr_a_rst),
        .rst_b_q      (tmr_b_rst),
        .adc_q        (adc_start)
    );

    assign pin_oe = oe;

endmodule

// File: tb/tcmp_unit_tb.sv
module tcmp_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0, cfg_addr = 1'b0;
    logic [W-1:0] cfg_wdata = '0, cnt_a = '0, cnt_b = '0;
    logic src_sel = 1'b0, adc_en = 1'b0, irq_clr = 1'b0;
    logic pin_out, pin_oe, irq_flag, tmr_a_rst, tmr_b_rst, adc_start;

    int vectors = 0, miscompares = 0;
    bit done = 1'b0;

    // reference model state
    logic [W-1:0] m_cmp;
    logic [3:0]   m_mode;
    logic m_oe, m_prev, m_latch, m_flag, m_ra, m_rb, m_adc;

    always #(CLK_PERIOD/2) clk = ~clk;

    tcmp_unit #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cnt_a(cnt_a), .cnt_b(cnt_b),
        .src_sel(src_sel), .adc_en(adc_en), .irq_clr(irq_clr),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_flag(irq_flag),
        .tmr_a_rst(tmr_a_rst), .tmr_b_rst(tmr_b_rst), .adc_start(adc_start)
    );

    function automatic bit mode_live(input logic [3:0] m);
        return m == 4'b1000 || m == 4'b1001 || m == 4'b0010 ||
               m == 4'b1010 || m == 4'b1011;
    endfunction

    function automatic string tag_of(input logic [3:0] m);
        case (m)
            4'b1000: return "R3";
            4'b1001: return "R4";
            4'b0010: return "R5";
            4'b1010: return "R6";
            4'b1011: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string tag, input string nm, input logic a, input logic e, inout bit bad);
        if (a !== e) begin
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, nm, a, e, $time);
            bad = 1'b1;
        end
    endtask

    // one clock with current inputs: predict, step, compare
    task automatic cycle();
        logic [W-1:0] sel;
        bit hit, ev, cw, bad;
        logic n_latch, n_flag;
        string t;
        sel = src_sel ? cnt_b : cnt_a;
        hit = mode_live(m_mode) && (sel == m_cmp);        // R1
        ev  = hit && !m_prev;                              // R2
        cw  = cfg_we && cfg_addr;
        t   = tag_of(m_mode);
        n_latch = m_latch;
        if (ev) begin
            case (m_mode)
                4'b1000: n_latch = 1'b1;
                4'b1001: n_latch = 1'b0;
                4'b0010: n_latch = ~m_latch;
                default: ;
            endcase
        end
        if (cw && cfg_wdata == '0) n_latch = 1'b0;       // R10
        if (ev) n_flag = 1'b1;                             // R9
        else if (irq_clr || (cw && cfg_wdata[7])) n_flag = 1'b0;
        else n_flag = m_flag;
        @(posedge clk);
        m_latch = n_latch;
        m_flag  = n_flag;
        m_ra    = ev && m_mode == 4'b1011 && !src_sel;     // R7
        m_rb    = ev && m_mode == 4'b1011 && src_sel;
        m_adc   = ev && m_mode == 4'b1011 && adc_en;       // R8
        m_prev  = hit;
        if (cfg_we) begin
            if (cfg_addr) begin
                m_mode = cfg_wdata[3:0];
                m_oe   = cfg_wdata[4];
            end else m_cmp = cfg_wdata;
        end
        @(negedge clk);
        bad = 1'b0;
        chk(t, "pin_out", pin_out, m_latch, bad);
        chk("R11", "pin_oe", pin_oe, m_oe, bad);
        chk("R9", "irq_flag", irq_flag, m_flag, bad);
        chk("R7", "tmr_a_rst", tmr_a_rst, m_ra, bad);
        chk("R7", "tmr_b_rst", tmr_b_rst, m_rb, bad);
        chk("R8", "adc_start", adc_start, m_adc, bad);
        vectors++;
        if (bad) miscompares++;
        cfg_we = 1'b0; irq_clr = 1'b0;
    endtask

    task automatic wr(input logic a, input logic [W-1:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        cycle();
    endtask

    task automatic hold(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    initial begin
        logic [3:0] modes [8];
        int seed;
        bit bad;
        modes = '{4'b1000, 4'b1001, 4'b0010, 4'b1010, 4'b1011, 4'b0000, 4'b0101, 4'b1111};
        seed = 32'h1c3a;
        void'($urandom(seed));
        m_cmp = '0; m_mode = '0; m_oe = 0; m_prev = 0; m_latch = 0;
        m_flag = 0; m_ra = 0; m_rb = 0; m_adc = 0;
        cnt_a = 16'h00ff; cnt_b = 16'h00ff;
        repeat (3) @(negedge clk);
        // R12: reset state
        bad = 1'b0;
        chk("R12", "pin_out", pin_out, 1'b0, bad);
        chk("R12", "pin_oe", pin_oe, 1'b0, bad);
        chk("R12", "irq_flag", irq_flag, 1'b0, bad);
        chk("R12", "tmr_a_rst", tmr_a_rst, 1'b0, bad);
        chk("R12", "tmr_b_rst", tmr_b_rst, 1'b0, bad);
        chk("R12", "adc_start", adc_start, 1'b0, bad);
        vectors++; if (bad) miscompares++;
        rst_n = 1'b1;
        @(negedge clk);

        // R3 + R2: set mode, count held equal several cycles
        wr(1'b0, 16'h0040);
        wr(1'b1, 16'h0018);                 // mode 1000, oe=1 (R11)
        cnt_a = 16'h0040; hold(4);
        irq_clr = 1'b1; cycle();
        cnt_a = 16'h0041; hold(1);
        // R1: unselected timer equal has no effect
        cnt_b = 16'h0040; hold(2);
        // R4 clear then re-match
        wr(1'b1, 16'h0019);
        cnt_a = 16'h0040; hold(2); cnt_a = 0; hold(1);
        // R5 toggle twice
        wr(1'b1, 16'h0012);
        cnt_a = 16'h0040; hold(1); cnt_a = 0; hold(1); cnt_a = 16'h0040; hold(2);
        // R6 flag only, then R9 set wins over same-cycle clear
        wr(1'b1, 16'h001a); cnt_a = 0; hold(1);
        irq_clr = 1'b1; cycle();
        cnt_a = 16'h0040; irq_clr = 1'b1; cycle();
        cnt_a = 0; hold(1);
        // R7 + R8 special trigger on timer B, adc disabled then enabled
        src_sel = 1'b1; wr(1'b1, 16'h000b); cnt_b = 0; hold(1);
        adc_en = 1'b0; cnt_b = 16'h0040; hold(2);
        cnt_b = 0; hold(1); adc_en = 1'b1; cnt_b = 16'h0040; hold(2);
        src_sel = 1'b0; cnt_a = 0; hold(1); cnt_a = 16'h0040; hold(2);
        // R10: set latch, then zero write in a matching cycle
        wr(1'b1, 16'h0008); cnt_a = 0; hold(1);
        cnt_a = 16'h0040; hold(1); cnt_a = 0; hold(1);
        cnt_a = 16'h0040; wr(1'b1, 16'h0000); hold(2);
        // R9: control write with bit 7 clears flag
        wr(1'b1, 16'h0080);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            cnt_a   = 16'h0040 + W'($urandom_range(0, 2));
            cnt_b   = 16'h0040 + W'($urandom_range(0, 2));
            src_sel = ($urandom_range(0, 9) == 0) ? ~src_sel : src_sel;
            adc_en  = $urandom_range(0, 1);
            irq_clr = ($urandom_range(0, 5) == 0);
            case ($urandom_range(0, 19))
                0: begin cfg_we = 1; cfg_addr = 1;
                     cfg_wdata = {8'h00, 1'($urandom_range(0,1)), 2'b00,
                                  1'($urandom_range(0,1)), modes[$urandom_range(0,7)]}; end
                1: begin cfg_we = 1; cfg_addr = 0;
                     cfg_wdata = 16'h0040 + W'($urandom_range(0, 2)); end
                2: begin cfg_we = 1; cfg_addr = 1; cfg_wdata = '0; end
                default: ;
            endcase
            cycle();
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule